// File: doc/BRIEF.md
# 8-bit ALU with selective flag update

This block is the arithmetic and logic core of a small 8-bit processor datapath. Each cycle it takes a left operand, a right operand and a 5-bit operation code, and returns an 8-bit result and a strobe. The strobe tells the surrounding datapath whether the result is meant to be written to a destination. The result and the strobe are combinational.

The block holds two registered condition flags, carry and zero. Each operation has its own update mask. Arithmetic, increment/decrement and shift/rotate operations rewrite both flags. Bitwise operations, test and complement rewrite only zero. Compare and test set flags but request no write.

Three further operations treat the flag register itself as the destination. In these, an 8-bit flag image (carry in bit 2, zero in bit 1, every other bit reads as zero) is combined with the right operand. The new flags are then taken from bits 2 and 1 of that combination. The flags change only on a rising clock edge with the enable high, and they reset to zero.

Top module: `alu8_flags`

## Requirements
- R1: After reset (active-low `rst_n`), `carry`, `zero` and every bit of `flag_img` are 0.
- R2: Op 0 (add) and op 1 (add with carry) produce lhs+rhs, plus the current carry for op 1. The result is written. Carry becomes the ninth sum bit and zero becomes (result==0).
- R3: Op 2 (subtract) and op 3 (subtract with borrow) produce lhs-rhs, minus the current carry for op 3, modulo 256. The result is written. Carry becomes 1 on unsigned underflow and zero becomes (result==0).
- R4: Op 4 (AND), op 5 (OR), op 6 (XOR) and op 9 (complement of lhs) write their result. They update zero only; carry keeps its value.
- R5: Op 7 (compare) requests no write. It sets zero when lhs==rhs and carry when lhs<rhs, both unsigned.
- R6: Op 8 (test) requests no write. It sets zero when (lhs & rhs)==0 and leaves carry unchanged.
- R7: Op 10 (increment lhs) and op 11 (decrement lhs) write their result. Carry is set on wrap from 0xFF to 0x00 (increment) or from 0x00 to 0xFF (decrement), and zero becomes (result==0).
- R8: Ops 12 to 15 act on lhs and write their result, with zero from the result:
  - op 12 shifts left, fills bit 0 with 0 and sends bit 7 to carry;
  - op 13 shifts right, keeps bit 7 and sends bit 0 to carry;
  - op 14 rotates left through carry;
  - op 15 rotates right through carry.
- R9: Ops 16, 17 and 18 AND, OR or XOR `rhs` into the flag image (bit 2 = carry, bit 1 = zero, other bits 0). They request no write and show the combined image on `result`. The new carry is bit 2 and the new zero is bit 1 of that image.
- R10: With `en` low, `wr_result` is 0 and both flags hold.
- R11: Op codes 19 to 31 request no write and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| en | input | 1 | Operation valid; allows the flag update and the write strobe |
| op | input | 5 | Operation code |
| lhs | input | 8 | Left operand |
| rhs | input | 8 | Right operand or immediate |
| result | output | 8 | Operation result (combined flag image for ops 16-18) |
| wr_result | output | 1 | Result should be written to its destination |
| flag_img | output | 8 | Flag image: carry at bit 2, zero at bit 1 |
| carry | output | 1 | Registered carry flag |
| zero | output | 1 | Registered zero flag |

## Verification
Every operation code is driven with all 256 left operands. Each is paired with sixteen right operands:
- fixed corners: 0x00, 0x01, 0x7F, 0x80, 0xFF and a few bit patterns;
- operand-relative values: equal to lhs, lhs+1 and lhs-1.

The equal and adjacent operands separate the equality and less-than outcomes of compare and borrow. The 0xFF and 0x00 left operands expose the carry-out, increment-wrap and decrement-wrap cases. The carry is left to evolve across the sweep, so add-with-carry, subtract-with-borrow and both rotates see both carry values. A final pass with the enable low, and another over the unused codes, shows that the flags are held.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W     = 8,
  parameter int C_POS = 2,
  parameter int Z_POS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [4:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] result,
  output logic         wr_result,
  output logic [W-1:0] flag_img,
  output logic         carry,
  output logic         zero
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6,  OP_CMP = 5'd7;
  localparam logic [4:0] OP_TST = 5'd8,  OP_CPL = 5'd9,  OP_INC = 5'd10, OP_DEC = 5'd11;
  localparam logic [4:0] OP_ASL = 5'd12, OP_ASR = 5'd13, OP_RLC = 5'd14, OP_RRC = 5'd15;
  localparam logic [4:0] OP_FAND = 5'd16, OP_FOR = 5'd17, OP_FXOR = 5'd18;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic c_q, z_q;
  logic [W-1:0] img, res;
  logic [W:0] add_x, sub_x;
  logic c_n, z_n, wr, upd;

  always_comb begin
    img = '0;
    img[C_POS] = c_q;
    img[Z_POS] = z_q;
  end

  assign add_x = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, (op == OP_ADC) & c_q};
  assign sub_x = {1'b0, lhs} - {1'b0, rhs} - {{W{1'b0}}, (op == OP_SBB) & c_q};

  always_comb begin
    res = '0;
    c_n = c_q;
    z_n = z_q;
    wr  = 1'b0;
    upd = 1'b1;
    case (op)
      OP_ADD, OP_ADC: begin res = add_x[W-1:0]; c_n = add_x[W]; z_n = (res == '0); wr = 1'b1; end
      OP_SUB, OP_SBB: begin res = sub_x[W-1:0]; c_n = sub_x[W]; z_n = (res == '0); wr = 1'b1; end
      OP_AND: begin res = lhs & rhs; z_n = (res == '0); wr = 1'b1; end
      OP_OR:  begin res = lhs | rhs; z_n = (res == '0); wr = 1'b1; end
      OP_XOR: begin res = lhs ^ rhs; z_n = (res == '0); wr = 1'b1; end
      OP_CMP: begin res = sub_x[W-1:0]; c_n = sub_x[W]; z_n = (res == '0); end
      OP_TST: begin res = lhs & rhs; z_n = (res == '0); end
      OP_CPL: begin res = ~lhs; z_n = (res == '0); wr = 1'b1; end
      OP_INC: begin res = lhs + ONE; c_n = (lhs == '1); z_n = (res == '0); wr = 1'b1; end
      OP_DEC: begin res = lhs - ONE; c_n = (lhs == '0); z_n = (res == '0); wr = 1'b1; end
      OP_ASL: begin res = {lhs[W-2:0], 1'b0}; c_n = lhs[W-1]; z_n = (res == '0); wr = 1'b1; end
      OP_ASR: begin res = {lhs[W-1], lhs[W-1:1]}; c_n = lhs[0]; z_n = (res == '0); wr = 1'b1; end
      OP_RLC: begin res = {lhs[W-2:0], c_q}; c_n = lhs[W-1]; z_n = (res == '0); wr = 1'b1; end
      OP_RRC: begin res = {c_q, lhs[W-1:1]}; c_n = lhs[0]; z_n = (res == '0); wr = 1'b1; end
      OP_FAND: begin res = img & rhs; c_n = res[C_POS]; z_n = res[Z_POS]; end
      OP_FOR:  begin res = img | rhs; c_n = res[C_POS]; z_n = res[Z_POS]; end
      OP_FXOR: begin res = img ^ rhs; c_n = res[C_POS]; z_n = res[Z_POS]; end
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q <= 1'b0;
      z_q <= 1'b0;
    end else if (en && upd) begin
      c_q <= c_n;
      z_q <= z_n;
    end
  end

  assign result    = res;
  assign wr_result = wr & en;
  assign flag_img  = img;
  assign carry     = c_q;
  assign zero      = z_q;
endmodule

module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [4:0] op,
  input logic [7:0] lhs,
  input logic [7:0] rhs,
  input logic [7:0] result,
  input logic       wr_result,
  input logic [7:0] flag_img,
  input logic       carry,
  input logic       zero
);
  p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd0 |=> carry == (({1'b0, $past(lhs)} + {1'b0, $past(rhs)}) > 9'd255));
  p_logic_keeps_c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && (op == 5'd4 || op == 5'd5 || op == 5'd6 || op == 5'd9) |=> $stable(carry));
  p_cmp_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd7 |=> zero == ($past(lhs) == $past(rhs)) && carry == ($past(lhs) < $past(rhs)));
  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == 5'd7 |-> !wr_result);
  p_tst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd8 |-> !wr_result ##1 $stable(carry));
  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd10 |=> carry == ($past(lhs) == 8'hFF));
  p_asl_bit7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd12 |=> carry == $past(lhs[7]));
  p_fand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en && op == 5'd16 |=> carry == ($past(flag_img[2]) & $past(rhs[2])) && zero == ($past(flag_img[1]) & $past(rhs[1])));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !wr_result ##1 $stable(flag_img));
  p_unused_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op > 5'd18 |-> !wr_result ##1 $stable(flag_img));
endmodule

bind alu8_flags alu8_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .lhs(lhs), .rhs(rhs),
  .result(result), .wr_result(wr_result), .flag_img(flag_img),
  .carry(carry), .zero(zero)
);

// File: tb/sim_alu8_flags.sv
`timescale 1ns/1ps
module sim_alu8_flags;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] lhs = '0, rhs = '0;
  logic [7:0] result, flag_img;
  logic wr_result, carry, zero;
  int checks = 0, failures = 0;
  bit mc = 0, mz = 0;

  always #2.5 clk = ~clk;

  alu8_flags u0 (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .lhs(lhs), .rhs(rhs),
                 .result(result), .wr_result(wr_result), .flag_img(flag_img),
                 .carry(carry), .zero(zero));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (op=%0d lhs=%0h rhs=%0h)", tag, what, act, exp, op, lhs, rhs);
    end
  endtask

  function automatic string tag_of(input int o, input bit e);
    if (!e) return "R10";
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4, 5, 6, 9: return "R4";
      7: return "R5";
      8: return "R6";
      10, 11: return "R7";
      12, 13, 14, 15: return "R8";
      16, 17, 18: return "R9";
      default: return "R11";
    endcase
  endfunction

  // returns {wr, result[7:0], carry, zero}
  function automatic logic [10:0] model(input int o, input int a, input int b, input bit c, input bit z);
    int r = 0;
    int img = c * 4 + z * 2;
    bit wr = 0, nc = c, nz = z;
    case (o)
      0: begin r = a + b; nc = r > 255; wr = 1; end
      1: begin r = a + b + c; nc = r > 255; wr = 1; end
      2: begin r = a - b; nc = a < b; wr = 1; end
      3: begin r = a - b - c; nc = a < b + c; wr = 1; end
      4: begin r = a & b; wr = 1; end
      5: begin r = a | b; wr = 1; end
      6: begin r = a ^ b; wr = 1; end
      7: begin nz = (a == b); nc = a < b; end
      8: nz = ((a & b) == 0);
      9: begin r = ~a; wr = 1; end
      10: begin r = a + 1; nc = (a == 255); wr = 1; end
      11: begin r = a - 1; nc = (a == 0); wr = 1; end
      12: begin r = a << 1; nc = (a >> 7) & 1; wr = 1; end
      13: begin r = (a >> 1) | (a & 128); nc = a & 1; wr = 1; end
      14: begin r = (a << 1) | c; nc = (a >> 7) & 1; wr = 1; end
      15: begin r = (a >> 1) | (c << 7); nc = a & 1; wr = 1; end
      16: r = img & b;
      17: r = img | b;
      18: r = img ^ b;
      default: ;
    endcase
    r = r & 255;
    if (wr) nz = (r == 0);
    if (o >= 16 && o <= 18) begin nc = (r >> 2) & 1; nz = (r >> 1) & 1; end
    return {wr, r[7:0], nc, nz};
  endfunction

  task automatic apply(input int o, input int a, input int b, input bit e);
    logic [10:0] x;
    string t;
    @(negedge clk);
    op = o[4:0]; lhs = a[7:0]; rhs = b[7:0]; en = e;
    #1;
    x = model(o, a, b, mc, mz);
    t = tag_of(o, e);
    chk(wr_result == (x[10] & e), t, "wr_result", wr_result, x[10] & e);
    if (e && (x[10] || (o >= 16 && o <= 18)))
      chk(result == x[9:2], t, "result", result, x[9:2]);
    @(posedge clk);
    #1;
    if (e) begin mc = x[1]; mz = x[0]; end
    chk(carry == mc, t, "carry", carry, mc);
    chk(zero == mz, t, "zero", zero, mz);
    chk(flag_img == {5'b0, mc, mz, 1'b0}, t, "flag_img", flag_img, {5'b0, mc, mz, 1'b0});
  endtask

  function automatic int pick(input int k, input int a);
    case (k)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h0F;
      4: return 8'h10;  5: return 8'h55;  6: return 8'h7F;  7: return 8'h80;
      8: return 8'h81;  9: return 8'hAA;  10: return 8'hF0; 11: return 8'hFE;
      12: return 8'hFF; 13: return a;     14: return (a + 1) & 255;
      default: return (a - 1) & 255;
    endcase
  endfunction

  initial begin
    #(190000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(carry == 1'b0, "R1", "carry after reset", carry, 0);
    chk(zero == 1'b0, "R1", "zero after reset", zero, 0);
    chk(flag_img == 8'h00, "R1", "flag_img after reset", flag_img, 0);

    for (int o = 0; o <= 18; o++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          apply(o, a, pick(k, a), 1'b1);

    // R10: enable low, flags set to a known non-zero state first
    apply(17, 0, 8'h06, 1'b1);
    for (int o = 0; o <= 18; o++)
      for (int k = 0; k < 16; k++)
        apply(o, (k * 37) & 255, pick(k, 3), 1'b0);
    apply(18, 0, 8'h02, 1'b1);
    for (int o = 0; o <= 18; o++)
      apply(o, 8'h00, 8'hFF, 1'b0);

    // R11: unused codes with both flag states
    for (int s = 0; s < 4; s++) begin
      apply(16, 0, 8'h00, 1'b1);
      apply(17, 0, s * 2, 1'b1);
      for (int o = 19; o < 32; o++)
        for (int k = 0; k < 16; k++)
          apply(o, 8'hFF - k, pick(k, 0), 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule